// File: doc/BRIEF.md
# Register writeback with zero-register rules

This block holds the integer register state of a 64-bit RISC core: 32 entries of 64 bits, two combinational read ports and one write port. The write port does not take raw register writes. It takes writeback requests that carry a destination index, a result, a flag marking a 32-bit operation, and a class: ALU, load, branch-and-link, or none. Alongside each request comes a fault indication from the memory side. The block applies the architectural rules itself: it sign-extends narrow results, discards any write aimed at the hardwired zero register, and turns loads into that register into fault-free prefetch hints.

The block has no condition-flag state. Control flow does not appear here at all. A branch-and-link that names the zero register as its link target still takes its branch elsewhere in the core, and only its link write is dropped. A fault or a hint is reported as a registered pulse that lasts one cycle, in the cycle after the request. The trap logic and the memory system read these pulses.

Control is a single decision per request, taken on the request class: ALU, load, link, or none. There is no multi-cycle state apart from the two pulse registers.

Top module: `wb_regfile`

## Requirements
- R1: A synchronous active-high reset clears entries 0 to 30, so every read port returns zero afterwards. The reset also clears both pulse outputs.
- R2: Index 31 reads as zero on both read ports at all times. A request of any class aimed at index 31 leaves every entry unchanged.
- R3: For ALU and load requests with the narrow flag set, the stored value is bits 31:0 of the result, with bit 31 copied into bits 63:32.
- R4: For ALU and load requests with the narrow flag clear, all 64 result bits are stored unchanged.
- R5: A load to index 31 raises `hint_pulse` for one cycle in the cycle after the request. It never raises `fault_pulse`, whatever the fault input says, and it writes nothing.
- R6: A load with the fault input set and a destination other than 31 raises `fault_pulse` for one cycle in the cycle after the request. The destination register keeps its old value.
- R7: A link request (class code 2) stores the result with bits 1:0 forced to zero and ignores the narrow flag. A link to index 31 stores nothing and raises neither pulse.
- R8: A read of the index being written in the same cycle returns the value after the writeback rules have been applied (write-first).
- R9: The fault input is ignored for ALU (class 0) and link requests. Class code 3 writes nothing and raises no pulse.
- R10: While `wb_valid` is low, no entry changes and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | 64 | Read port A data |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | 64 | Read port B data |
| wb_valid | input | 1 | Writeback request present |
| wb_idx | input | 5 | Destination index |
| wb_data | input | 64 | Result value |
| wb_narrow | input | 1 | 32-bit operation flag |
| wb_kind | input | 2 | Class: 0 ALU, 1 load, 2 link, 3 none |
| ld_fault | input | 1 | Memory fault for the current load |
| fault_pulse | output | 1 | Load fault to raise, one cycle after the request |
| hint_pulse | output | 1 | Load was a prefetch hint, one cycle after the request |

## Verification
The bench checks narrow results with bit 31 both set and clear. A design that zero-extends shows a clean upper half where ones are expected. The bench also sends faulting loads to index 31. A design that forgets the suppression raises a fault pulse instead of a hint, or else stores data. Two more cases target dropped writes. Writes of every class to index 31 would make that index read nonzero if the squash were missing. Faulting loads to other registers would corrupt the target if the write were not blocked. Same-cycle read-after-write and link alignment are checked on every random request against a software model. A stale bypass or untrimmed low bits therefore show up within the random run.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_LOAD = 2'd1,
        WB_LINK = 2'd2,
        WB_NONE = 2'd3
    } wb_kind_e;
endpackage

// File: rtl/wb_resolve.sv
module wb_resolve #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int HALF = 32,
    localparam int AW  = $clog2(NREG),
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1)
) (
    input  logic            req_valid,
    input  logic [AW-1:0]   req_idx,
    input  logic [XLEN-1:0] req_data,
    input  logic            req_narrow,
    input  logic [1:0]      req_kind,
    input  logic            req_fault,
    output logic            we,
    output logic [AW-1:0]   widx,
    output logic [XLEN-1:0] wval,
    output logic            fault_now,
    output logic            hint_now
);
    import wb_pkg::*;

    logic            to_zero;
    logic [XLEN-1:0] sized;
    wb_kind_e        kind;

    assign kind    = wb_kind_e'(req_kind);
    assign to_zero = (req_idx == ZERO_IDX);
    assign widx    = req_idx;
    assign sized   = req_narrow ? {{(XLEN-HALF){req_data[HALF-1]}}, req_data[HALF-1:0]}
                                : req_data;

    always_comb begin
        we        = 1'b0;
        wval      = sized;
        fault_now = 1'b0;
        hint_now  = 1'b0;
        if (req_valid) begin
            unique case (kind)
                WB_ALU: begin
                    we = !to_zero;
                end
                WB_LOAD: begin
                    hint_now  = to_zero;
                    fault_now = !to_zero && req_fault;
                    we        = !to_zero && !req_fault;
                end
                WB_LINK: begin
                    we   = !to_zero;
                    wval = {req_data[XLEN-1:2], 2'b00};
                end
                WB_NONE: begin
                    we = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/wb_regarray.sv
module wb_regarray #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   widx,
    input  logic [XLEN-1:0] wval,
    input  logic [AW-1:0]   ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] rb_data
);
    logic [XLEN-1:0] store [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == NREG - 1) begin : g_zero
            assign store[g] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    store[g] <= '0;
                else if (we && widx == AW'(g))
                    store[g] <= wval;
            end
        end
    end

    function automatic logic [XLEN-1:0] pick(input logic [AW-1:0] idx);
        if (idx == ZERO_IDX)
            return '0;
        else if (we && widx == idx)
            return wval;
        else
            return store[idx];
    endfunction

    always_comb ra_data = pick(ra_idx);
    always_comb rb_data = pick(rb_idx);

    a_r2_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        we |-> widx != ZERO_IDX);
endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int HALF = 32,
    localparam int AW  = $clog2(NREG),
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_idx_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_idx_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wb_valid,
    input  logic [AW-1:0]   wb_idx,
    input  logic [XLEN-1:0] wb_data,
    input  logic            wb_narrow,
    input  logic [1:0]      wb_kind,
    input  logic            ld_fault,
    output logic            fault_pulse,
    output logic            hint_pulse
);
    import wb_pkg::*;

    logic            we;
    logic [AW-1:0]   widx;
    logic [XLEN-1:0] wval;
    logic            fault_now, hint_now;
    logic            fault_q, hint_q;

    wb_resolve #(.XLEN(XLEN), .NREG(NREG), .HALF(HALF)) resolve_i (
        .req_valid (wb_valid),
        .req_idx   (wb_idx),
        .req_data  (wb_data),
        .req_narrow(wb_narrow),
        .req_kind  (wb_kind),
        .req_fault (ld_fault),
        .we        (we),
        .widx      (widx),
        .wval      (wval),
        .fault_now (fault_now),
        .hint_now  (hint_now)
    );

    wb_regarray #(.XLEN(XLEN), .NREG(NREG)) array_i (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .widx   (widx),
        .wval   (wval),
        .ra_idx (rd_idx_a),
        .ra_data(rd_data_a),
        .rb_idx (rd_idx_b),
        .rb_data(rd_data_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            hint_q  <= 1'b0;
        end else begin
            fault_q <= fault_now;
            hint_q  <= hint_now;
        end
    end

    assign fault_pulse = fault_q;
    assign hint_pulse  = hint_q;

    a_r5_hint_source: assert property (@(posedge clk) disable iff (rst)
        hint_pulse |-> $past(wb_valid && wb_kind == WB_LOAD && wb_idx == ZERO_IDX));
    a_r6_fault_source: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> $past(wb_valid && wb_kind == WB_LOAD && ld_fault && wb_idx != ZERO_IDX));
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fault_pulse && hint_pulse));
    a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_b == ZERO_IDX) |-> rd_data_b == '0);
    a_r7_link_aligned: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_kind == WB_LINK && wb_idx != ZERO_IDX && rd_idx_a == wb_idx)
        |-> rd_data_a[1:0] == 2'b00);
    a_r3_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_narrow && wb_kind == WB_ALU && wb_idx != ZERO_IDX && rd_idx_a == wb_idx)
        |-> rd_data_a[XLEN-1:HALF] == {(XLEN-HALF){rd_data_a[HALF-1]}});
endmodule

// File: tb/wb_regfile_tb.sv
`timescale 1ns/1ps
module wb_regfile_tb_top;
    localparam int PER = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_idx_a = '0, rd_idx_b = '0;
    logic [63:0] rd_data_a, rd_data_b;
    logic        wb_valid = 1'b0;
    logic [4:0]  wb_idx = '0;
    logic [63:0] wb_data = '0;
    logic        wb_narrow = 1'b0;
    logic [1:0]  wb_kind = '0;
    logic        ld_fault = 1'b0;
    logic        fault_pulse, hint_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    logic [63:0] mdl [32];
    logic [1:0]  expq [$];

    always #(PER/2) clk = ~clk;

    wb_regfile dut_i (
        .clk(clk), .rst(rst),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_narrow(wb_narrow), .wb_kind(wb_kind), .ld_fault(ld_fault),
        .fault_pulse(fault_pulse), .hint_pulse(hint_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops {fault,hint} expected after each edge; an empty queue means idle.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                logic [1:0] e;
                e = (expq.size() > 0) ? expq.pop_front() : 2'b00;
                chk("R5/R6 pulses", {62'd0, fault_pulse, hint_pulse}, {62'd0, e});
            end
        end
    end

    // Driver: applies one request, checks the same-cycle read, pushes expected pulses.
    task automatic do_wb(input bit v, input logic [4:0] idx, input logic [63:0] d,
                         input bit nar, input logic [1:0] k, input bit f, input string req);
        bit          wr;
        logic [63:0] nv;
        bit          ef, eh;
        @(negedge clk);
        wb_valid = v; wb_idx = idx; wb_data = d; wb_narrow = nar; wb_kind = k; ld_fault = f;
        nv = (k == 2'd2) ? {d[63:2], 2'b00} : (nar ? {{32{d[31]}}, d[31:0]} : d);
        wr = v && idx != 5'd31 && (k == 2'd0 || k == 2'd2 || (k == 2'd1 && !f));
        ef = v && k == 2'd1 && f && idx != 5'd31;
        eh = v && k == 2'd1 && idx == 5'd31;
        rd_idx_a = idx;
        rd_idx_b = 5'd31;
        #1;
        chk({req, " R8 same-cycle read"}, rd_data_a, wr ? nv : mdl[idx]);
        chk("R2 zero port B", rd_data_b, 64'd0);
        expq.push_back({ef, eh});
        @(posedge clk);
        if (wr) mdl[idx] = nv;
        #1;
        wb_valid = 1'b0; ld_fault = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, input string req);
        rd_idx_a = idx; rd_idx_b = idx;
        #1;
        chk({req, " port A"}, rd_data_a, mdl[idx]);
        chk({req, " port B"}, rd_data_b, mdl[idx]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < 32; i++) rd(5'(i), "R1 reset");

        // R3: narrow with bit 31 set and clear, upper garbage ignored
        do_wb(1, 5'd3, 64'h1234_5678_8000_0001, 1, 2'd0, 0, "R3 neg");
        rd(5'd3, "R3 neg");
        do_wb(1, 5'd4, 64'hFFFF_0000_7FFF_FFFF, 1, 2'd1, 0, "R3 pos load");
        rd(5'd4, "R3 pos load");
        // R4 full width
        do_wb(1, 5'd5, 64'hDEAD_BEEF_CAFE_F00D, 0, 2'd0, 0, "R4 wide");
        rd(5'd5, "R4 wide");
        // R2 writes of each class to 31
        do_wb(1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd0, 0, "R2 alu31");
        do_wb(1, 5'd31, 64'h1000, 0, 2'd2, 0, "R7 link31");
        rd(5'd31, "R2 zero");
        // R5 loads to 31, faulting and not
        do_wb(1, 5'd31, 64'h55, 0, 2'd1, 1, "R5 hint faulting");
        do_wb(1, 5'd31, 64'h66, 1, 2'd1, 0, "R5 hint");
        rd(5'd31, "R5 zero");
        // R6 faulting load keeps old value
        do_wb(1, 5'd5, 64'h1111, 0, 2'd1, 1, "R6 fault");
        rd(5'd5, "R6 kept");
        // R7 link trims low bits, ignores narrow flag
        do_wb(1, 5'd26, 64'h8000_0000_0000_1237, 1, 2'd2, 0, "R7 link");
        rd(5'd26, "R7 link");
        // R9 fault ignored for ALU/link, class 3 inert
        do_wb(1, 5'd7, 64'h42, 0, 2'd0, 1, "R9 alu fault");
        do_wb(1, 5'd8, 64'h44, 0, 2'd2, 1, "R9 link fault");
        do_wb(1, 5'd7, 64'h99, 0, 2'd3, 1, "R9 none");
        rd(5'd7, "R9 kept");
        rd(5'd8, "R9 link");
        // R10 valid low
        do_wb(0, 5'd7, 64'h77, 0, 2'd1, 1, "R10 idle");
        rd(5'd7, "R10 kept");

        for (int n = 0; n < 400; n++) begin
            logic [4:0]  ri;
            logic [63:0] rdv;
            ri  = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
            rdv = {$urandom, $urandom};
            do_wb(($urandom % 8) != 0, ri, rdv, 1'($urandom), 2'($urandom),
                  ($urandom % 3) == 0, "R3/R5/R6 random");
            rd(5'($urandom), "R4 random read");
        end
        for (int i = 0; i < 32; i++) rd(5'(i), "R2 final sweep");

        @(negedge clk);
        mon_on = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        for (int i = 0; i < 32; i++) rd(5'(i), "R1 second reset");
        chk("R1 pulses cleared", {62'd0, fault_pulse, hint_pulse}, 64'd0);
        finish_run();
    end
endmodule